// File: doc/BRIEF.md
# I2C EEPROM Page-Write Target

This block behaves as a small serial EEPROM on an I2C bus. It runs on a system clock. It takes SCL and SDA samples that are already synchronized, a write-protect level and three board-strapped address bits. Its outputs are an enable that pulls SDA low and a flag that is high during the internal write cycle. A transaction begins with a device-select byte. A write then carries a word address and a run of data bytes. A read shifts out stored bytes, either from an address just loaded (random read) or from the address held inside the block (current-address read).

Written bytes are only collected in a page buffer while they arrive. Nothing reaches the byte array until a STOP ends the transaction. STOP starts one timed write cycle for the whole page. The bytes are committed at the end of that cycle, unless write-protect rises first. While the cycle runs the block refuses every command. Within a page write only the in-page address bits advance, so a write that runs past the end of the page continues at the start of the same page.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A device-select byte is acknowledged only when its upper seven bits equal binary 1010 followed by `hw_addr_i` (MSB first). Bit 0 selects read (1) or write (0). Any other byte gets no acknowledge, and the block ignores the bus until the next START.
- R2: The word address is the byte sent after a write select. Only its low log2(MEM_BYTES) bits are used and higher bits are ignored. With the default 128 bytes, address byte 8Eh selects location 0Eh.
- R3: Each acknowledged data byte goes to the current address. Only the low log2(PAGE_BYTES) bits then advance, wrapping within the page, and the upper bits never change. With 16-byte pages, a write started at 0Eh fills 0Eh, 0Fh, 00h, 01h.
- R4: Data bytes change the array only if a STOP ends the transaction. `busy_o` stays low while bytes arrive. A repeated START after data bytes drops them and starts no write cycle.
- R5: A STOP after at least one acknowledged data byte, with `wp_i` low, holds `busy_o` high for exactly WRITE_CYCLES clock cycles. This holds for one byte and for a full page alike.
- R6: While `busy_o` is high, a matching device-select byte is not acknowledged.
- R7: If `wp_i` is high at the STOP, data bytes are still acknowledged but are discarded. `busy_o` stays low and the array is unchanged.
- R8: If `wp_i` goes high during the write cycle, `busy_o` falls on the next clock edge and no byte of the pending page is stored.
- R9: A read drives each byte MSB first, changing SDA only while SCL is low, and releases SDA in the acknowledge slot. After each byte the controller acknowledges, the current address advances by one across the whole array, wrapping from the top to 00h.
- R10: A read select without a word address starts at the current address. A controller NACK ends the read and leaves the current address where it was.
- R11: After reset `busy_o` is low and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample (wired bus level) |
| wp_i | input | 1 | Write-protect level, high forbids writes |
| hw_addr_i | input | 3 | Board-strapped device address bits |
| sda_pull_o | output | 1 | High pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A wrong bit counter or state shows up at the ports within one byte: the acknowledge moves out of its slot, or read data comes out shifted by one bit. A fault in page-index arithmetic or in the commit does not show on the bus during the write. It appears only when the locations are read back after the write cycle, as a byte in the wrong place or a missing byte. A wrong timer shows as a `busy_o` pulse of the wrong length, or as a select that is acknowledged during the cycle. A missed protect check shows as a byte that changed even though write-protect was high.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RD_FIRST,
    ST_RDATA
  } ee_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // Upper seven bits of a select byte must equal the fixed code plus strap bits.
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] hw);
    return b[7:1] == {DEV_CODE, hw};
  endfunction

  // Advance only the bits under pmask, keep the rest (no carry out of the page).
  function automatic logic [7:0] page_step(input logic [7:0] a, input logic [7:0] pmask);
    return (a & ~pmask) | ((a + 8'd1) & pmask);
  endfunction

  // Advance across the whole array, wrapping at amask.
  function automatic logic [7:0] array_step(input logic [7:0] a, input logic [7:0] amask);
    return (a + 8'd1) & amask;
  endfunction

endpackage

// File: rtl/i2c_ee_bus_events.sv
module i2c_ee_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/i2c_ee_page_buf.sv
module i2c_ee_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int PG_W = $clog2(PAGE_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       wr_en_i,
  input  logic [PG_W-1:0]            wr_idx_i,
  input  logic [7:0]                 wr_data_i,
  output logic [PAGE_BYTES-1:0][7:0] data_o,
  output logic [PAGE_BYTES-1:0]      valid_o
);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        data_o[g]  <= 8'h00;
      end else if (clear_i) begin
        valid_o[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == PG_W'(g)) begin
        valid_o[g] <= 1'b1;
        data_o[g]  <= wr_data_i;
      end
    end
  end

  AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !clear_i |=> valid_o[$past(wr_idx_i)]); // R3

endmodule

// File: rtl/i2c_ee_wcycle.sv
module i2c_ee_wcycle #(
  parameter int CYCLES = 400,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wp_i,
  output logic busy_o,
  output logic commit_o
);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end   = cnt == LAST;
  assign commit_o = busy_o && !wp_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt    <= '0;
      end
    end else if (wp_i || at_end) begin
      busy_o <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && wp_i |=> !busy_o); // R8
  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_o); // R5
  AST_START_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o); // R5

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int MEM_BYTES    = 128,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [2:0] hw_addr_i,
  output logic       sda_pull_o,
  output logic       busy_o
);
  localparam int         ADDR_W = $clog2(MEM_BYTES);
  localparam int         PG_W   = $clog2(PAGE_BYTES);
  localparam logic [7:0] AMASK  = 8'(MEM_BYTES - 1);
  localparam logic [7:0] PMASK  = 8'(PAGE_BYTES - 1);

  // bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_ee_bus_events u_ev (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  // sequencer state
  ee_state_e  state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] txbyte;
  logic [7:0] cur_addr;
  logic [7:0] page_base;
  logic       pull;
  logic       have_data;
  logic       rd_nack;

  // write cycle and page buffer
  logic                       busy;
  logic                       commit;
  logic [PAGE_BYTES-1:0][7:0] pbuf_data;
  logic [PAGE_BYTES-1:0]      pbuf_valid;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] rd_byte;

  // named internal events
  logic byte_done, dev_byte_done, dev_ok, addr_byte_done, data_byte_done;
  logic ack_end, rd_ack_rise, wc_start;

  assign byte_done      = scl_fall && bitcnt == 4'd8 && state != ST_IDLE;
  assign dev_byte_done  = byte_done && state == ST_DEV;
  assign dev_ok         = dev_match(shreg, hw_addr_i) && !busy;
  assign addr_byte_done = byte_done && state == ST_WADDR;
  assign data_byte_done = byte_done && state == ST_WDATA;
  assign ack_end        = scl_fall && bitcnt == 4'd9 && state != ST_IDLE;
  assign rd_ack_rise    = scl_rise && bitcnt == 4'd8 && state == ST_RDATA;
  assign wc_start       = stop_ev && have_data && !wp_i && !busy;
  assign rd_byte        = mem[cur_addr[ADDR_W-1:0]];

  i2c_ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (addr_byte_done),
    .wr_en_i   (data_byte_done),
    .wr_idx_i  (cur_addr[PG_W-1:0]),
    .wr_data_i (shreg),
    .data_o    (pbuf_data),
    .valid_o   (pbuf_valid)
  );

  i2c_ee_wcycle #(.CYCLES(WRITE_CYCLES)) u_wc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (wc_start),
    .wp_i     (wp_i),
    .busy_o   (busy),
    .commit_o (commit)
  );

  // page commit into the array
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pbuf_valid[i]) mem[ADDR_W'(page_base | 8'(i))] <= pbuf_data[i];
      end
    end
  end

  // bit and byte sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txbyte    <= '0;
      cur_addr  <= '0;
      page_base <= '0;
      pull      <= 1'b0;
      have_data <= 1'b0;
      rd_nack   <= 1'b0;
    end else if (start_ev) begin
      state     <= ST_DEV;
      bitcnt    <= '0;
      pull      <= 1'b0;
      have_data <= 1'b0;
      rd_nack   <= 1'b0;
    end else if (stop_ev) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      pull      <= 1'b0;
      have_data <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_i};
        if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
        if (rd_ack_rise) begin
          rd_nack <= sda_i;
          if (!sda_i) cur_addr <= array_step(cur_addr, AMASK);
        end
      end
      if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          unique case (state)
            ST_DEV: begin
              if (dev_ok) begin
                pull  <= 1'b1;
                state <= shreg[0] ? ST_RD_FIRST : ST_WADDR;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WADDR: begin
              pull      <= 1'b1;
              cur_addr  <= shreg & AMASK;
              page_base <= shreg & AMASK & ~PMASK;
              state     <= ST_WDATA;
            end
            ST_WDATA: begin
              pull      <= 1'b1;
              have_data <= 1'b1;
              cur_addr  <= page_step(cur_addr, PMASK);
            end
            default: pull <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (state == ST_RD_FIRST || (state == ST_RDATA && !rd_nack)) begin
            txbyte <= rd_byte;
            pull   <= !rd_byte[7];
            state  <= ST_RDATA;
          end else begin
            pull <= 1'b0;
            if (state == ST_RDATA) state <= ST_IDLE;
          end
        end else if (state == ST_RDATA) begin
          pull <= !txbyte[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  assign sda_pull_o = pull;
  assign busy_o     = busy;

  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_byte_done && busy |=> !sda_pull_o); // R6
  AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    data_byte_done |=> (cur_addr & ~PMASK) == ($past(cur_addr) & ~PMASK)); // R3
  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev && wp_i |=> !busy_o); // R7
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i); // R9
  AST_DATA_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    data_byte_done |-> !busy_o); // R4

endmodule

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
  localparam int WC = 400;
  localparam int H  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       ctl_sda = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] hw = 3'b101;
  logic       sda_pull, busy;
  wire        sda_line = ctl_sda & ~sda_pull;

  int checks = 0;
  int fails = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;

  i2c_eeprom_target #(.MEM_BYTES(128), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .hw_addr_i(hw), .sda_pull_o(sda_pull), .busy_o(busy)
  );

  // select byte, expected acknowledge (hw = 101)
  localparam logic [8:0] DEV_VEC [0:7] = '{
    {8'hAA, 1'b1}, {8'hA8, 1'b0}, {8'hAE, 1'b0}, {8'hBA, 1'b0},
    {8'h2A, 1'b0}, {8'hEA, 1'b0}, {8'hA2, 1'b0}, {8'hAA, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    @(negedge clk); ctl_sda = 1'b1; ticks(H);
    scl = 1'b1; ticks(H);
    ctl_sda = 1'b0; ticks(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    @(negedge clk); ctl_sda = 1'b0; ticks(H);
    scl = 1'b1; ticks(H);
    ctl_sda = 1'b1; ticks(H);
  endtask

  task automatic stop_timed(output int n);
    @(negedge clk); ctl_sda = 1'b0; ticks(H);
    scl = 1'b1; ticks(H);
    ctl_sda = 1'b1;
    n = 0;
    for (int i = 0; i < WC + 50; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); ctl_sda = b[i]; ticks(H);
      scl = 1'b1; ticks(H);
      scl = 1'b0;
    end
    @(negedge clk); ctl_sda = 1'b1; ticks(H);
    scl = 1'b1; ticks(2);
    ack = !sda_line;
    ticks(H - 2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ctl_sda = 1'b1; ticks(H);
      scl = 1'b1; ticks(2);
      b = {b[6:0], sda_line};
      ticks(H - 2);
      scl = 1'b0;
    end
    @(negedge clk); ctl_sda = !give_ack; ticks(H);
    scl = 1'b1; ticks(H);
    scl = 1'b0;
  endtask

  // write select, address and n bytes from wbuf; no STOP
  task automatic do_write(input logic [7:0] addr, input int n, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(addr, a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      if (a) acks++;
    end
  endtask

  task automatic read_seq(input logic rnd, input logic [7:0] addr, input int n);
    logic a;
    bus_start();
    if (rnd) begin
      send_byte(8'hAA, a);
      send_byte(addr, a);
      bus_start();
    end
    send_byte(8'hAB, a);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin
    int n, acks;
    logic a;
    ticks(3);
    chk("R11 busy after reset", int'(busy), 0);
    chk("R11 sda released after reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    ticks(3);

    // R1: select decode table
    for (int v = 0; v < 8; v++) begin
      bus_start();
      send_byte(DEV_VEC[v][8:1], a);
      bus_stop();
      chk($sformatf("R1 select %0h", DEV_VEC[v][8:1]), int'(a), int'(DEV_VEC[v][0]));
    end

    // R2/R3/R4: write from 8Eh (bit 7 ignored), wraps within page
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(8'h8E, 4, acks);
    chk("R4 no busy before stop", int'(busy), 0);
    bus_stop();
    chk("R4 busy after stop", int'(busy), 1);
    bus_start();
    send_byte(8'hAA, a);
    bus_stop();
    chk("R6 select nacked while busy", int'(a), 0);
    while (busy) @(negedge clk);
    ticks(5);

    read_seq(1'b1, 8'h0E, 2);
    chk("R9 read 0Eh", int'(rbuf[0]), 'h11);
    chk("R9 read 0Fh", int'(rbuf[1]), 'h22);
    read_seq(1'b0, 8'h00, 1);
    chk("R10 current read after nack", int'(rbuf[0]), 'h22);
    read_seq(1'b1, 8'h80, 2);
    chk("R3 wrapped byte 00h", int'(rbuf[0]), 'h33);
    chk("R3 wrapped byte 01h", int'(rbuf[1]), 'h44);

    // R5: full page, one period
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'hA0 + i);
    do_write(8'h70, 16, acks);
    chk("R3 full page acks", acks, 16);
    stop_timed(n);
    chk("R5 full page cycle length", n, WC);
    read_seq(1'b1, 8'h7F, 2);
    chk("R9 read 7Fh", int'(rbuf[0]), 'hAF);
    chk("R9 wrap to 00h", int'(rbuf[1]), 'h33);

    wbuf[0] = 8'h5A;
    do_write(8'h10, 1, acks);
    stop_timed(n);
    chk("R5 single byte cycle length", n, WC);

    // R7: protected at stop
    wp = 1'b1;
    wbuf[0] = 8'h55;
    do_write(8'h0E, 1, acks);
    chk("R7 data acked under protect", acks, 1);
    stop_timed(n);
    chk("R7 no busy under protect", n, 0);
    wp = 1'b0;
    read_seq(1'b1, 8'h0E, 1);
    chk("R7 byte unchanged", int'(rbuf[0]), 'h11);

    // R8: protect raised mid-cycle
    wbuf[0] = 8'h66;
    do_write(8'h0F, 1, acks);
    bus_stop();
    ticks(20);
    chk("R8 busy before abort", int'(busy), 1);
    wp = 1'b1;
    ticks(2);
    chk("R8 busy drops on protect", int'(busy), 0);
    wp = 1'b0;
    ticks(WC + 20);
    read_seq(1'b1, 8'h0F, 1);
    chk("R8 byte not committed", int'(rbuf[0]), 'h22);

    // R4: repeated start drops data
    wbuf[0] = 8'h77;
    do_write(8'h00, 1, acks);
    bus_start();
    send_byte(8'hAB, a);
    recv_byte(1'b0, rbuf[0]);
    bus_stop();
    chk("R10 current read after write", int'(rbuf[0]), 'h44);
    chk("R4 no cycle after repeated start", int'(busy), 0);
    read_seq(1'b1, 8'h00, 1);
    chk("R4 dropped byte not stored", int'(rbuf[0]), 'h33);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule